// File: doc/BRIEF.md
# Vectored Interrupt Sequencer

This block sits beside a small processor core and decides when, and to which handler, the core should divert. It watches a bank of request lines, each tied to a fixed vector, together with a single global enable. At an instruction boundary it picks the pending source with the smallest vector number. It then walks the core through entry in two steps: a push of the interrupted program counter, followed by a redirect of fetch to the handler address. On the redirect cycle it sends a one-cycle acknowledge to the chosen source.

The global enable is owned here. Entry clears it, so handlers do not nest unless software turns it back on. A return strobe from the core sets it again. After every return the block insists that one ordinary instruction completes before another entry can begin, even when requests are already waiting. Software may also set or clear the enable directly.

Top module: `irq_sequencer`

## Requirements
- R1: Out of synchronous reset, the global enable reads 0 and push_pc, redirect and every irq_ack bit are 0.
- R2: Request bit i has vector number i+1, and its handler address is the vector number times 2, so bit 0 maps to address 2 and bit 24 to address 50.
- R3: When several enabled requests are pending at an entry, the one with the smallest vector number (lowest bit index) is served.
- R4: Entry starts only on a clock edge where the global enable is 1, at least one request is pending and insn_done is 1. push_pc is then high for exactly the next cycle, and push_val carries the pc_in value sampled on that edge.
- R5: redirect is high for exactly the cycle after push_pc, and vec_addr holds the winner's handler address during that cycle.
- R6: irq_ack is one-hot on the redirect cycle, with the winner's bit set, and all zero in every other cycle.
- R7: Entry clears the global enable, and no further entry happens while it stays 0, whatever requests or boundaries arrive.
- R8: A reti_done pulse outside an entry sequence sets the global enable on the next edge.
- R9: After a reti_done, the first insn_done pulse cannot start an entry; only a later one can.
- R10: sw_gie_set sets the enable and sw_gie_clr clears it; when both are asserted together, clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_SRC | Pending request per source, bit i is vector i+1 |
| insn_done | input | 1 | Core finished an instruction this cycle |
| pc_in | input | PC_W | Program counter to save on entry |
| reti_done | input | 1 | Core completed a return from a handler |
| sw_gie_set | input | 1 | Software sets the global enable |
| sw_gie_clr | input | 1 | Software clears the global enable |
| gie | output | 1 | Current global enable |
| push_pc | output | 1 | Request to push push_val onto the stack |
| push_val | output | PC_W | Program counter to be pushed |
| redirect | output | 1 | Redirect fetch to vec_addr |
| vec_addr | output | PC_W | Handler address of the winning vector |
| irq_ack | output | NUM_SRC | One-hot acknowledge to the served source |

## Verification
The properties assume the core never raises reti_done while an entry sequence is running and never in the same cycle as insn_done, and that a source keeps its request up until it is acknowledged. The stimulus honours this: returns are issued only with the sequencer idle and no boundary pulse, boundaries are single-cycle pulses, and each request bit is dropped only after the acknowledge for it has been seen. Within those limits the bench mixes simultaneous requests, disabled periods and back-to-back returns to reach the priority and post-return gap cases.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_PUSH = 2'd1,
        SEQ_JUMP = 2'd2
    } seq_state_e;

    localparam int unsigned DEF_NUM_SRC = 25;
    localparam int unsigned DEF_PC_W    = 16;
    localparam int unsigned DEF_STRIDE  = 2;

    // handler address for a zero-based request index
    function automatic int unsigned handler_addr(input int unsigned idx,
                                                 input int unsigned stride);
        return (idx + 1) * stride;
    endfunction

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int unsigned N  = 25,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = |req;
        idx = '0;
        // scan from the top so the lowest set bit is left last
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/irq_gie_ctrl.sv
module irq_gie_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic busy,
    input  logic reti_done,
    input  logic insn_done,
    input  logic sw_set,
    input  logic sw_clr,
    output logic gie,
    output logic hold
);
    always_ff @(posedge clk) begin
        if (rst) begin
            gie  <= 1'b0;
            hold <= 1'b0;
        end else begin
            if (take) begin
                gie <= 1'b0;
            end else if (!busy) begin
                if (reti_done)   gie <= 1'b1;
                else if (sw_clr) gie <= 1'b0;
                else if (sw_set) gie <= 1'b1;
            end

            if (reti_done && !busy)   hold <= 1'b1;
            else if (insn_done)       hold <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_seq_pkg::*;
#(
    parameter int unsigned N      = 25,
    parameter int unsigned IW     = $clog2(N),
    parameter int unsigned PC_W   = 16,
    parameter int unsigned STRIDE = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic [IW-1:0]   win_idx,
    input  logic [PC_W-1:0] pc_in,
    output logic            busy,
    output logic            push_pc,
    output logic [PC_W-1:0] push_val,
    output logic            redirect,
    output logic [PC_W-1:0] vec_addr,
    output logic [N-1:0]    ack
);
    seq_state_e      state;
    logic [IW-1:0]   idx_q;
    logic [PC_W-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            idx_q <= '0;
            pc_q  <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: if (take) begin
                    state <= SEQ_PUSH;
                    idx_q <= win_idx;
                    pc_q  <= pc_in;
                end
                SEQ_PUSH: state <= SEQ_JUMP;
                SEQ_JUMP: state <= SEQ_IDLE;
                default:  state <= SEQ_IDLE;
            endcase
        end
    end

    assign busy     = (state != SEQ_IDLE);
    assign push_pc  = (state == SEQ_PUSH);
    assign push_val = push_pc ? pc_q : '0;
    assign redirect = (state == SEQ_JUMP);
    assign vec_addr = redirect ? PC_W'(handler_addr(32'(idx_q), STRIDE)) : '0;

    for (genvar g = 0; g < N; g++) begin : g_ack
        assign ack[g] = redirect && (idx_q == IW'(g));
    end
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
    import irq_seq_pkg::*;
#(
    parameter int unsigned NUM_SRC = DEF_NUM_SRC,
    parameter int unsigned PC_W    = DEF_PC_W,
    parameter int unsigned STRIDE  = DEF_STRIDE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               insn_done,
    input  logic [PC_W-1:0]    pc_in,
    input  logic               reti_done,
    input  logic               sw_gie_set,
    input  logic               sw_gie_clr,
    output logic               gie,
    output logic               push_pc,
    output logic [PC_W-1:0]    push_val,
    output logic               redirect,
    output logic [PC_W-1:0]    vec_addr,
    output logic [NUM_SRC-1:0] irq_ack
);
    localparam int unsigned IW = $clog2(NUM_SRC);

    logic          hit;
    logic [IW-1:0] win_idx;
    logic          busy;
    logic          hold;
    logic          take;

    irq_prio_enc #(.N(NUM_SRC), .IW(IW)) u_enc (
        .req (irq_req),
        .hit (hit),
        .idx (win_idx)
    );

    assign take = !busy && gie && hit && insn_done && !hold && !reti_done;

    irq_gie_ctrl u_gie (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .busy      (busy),
        .reti_done (reti_done),
        .insn_done (insn_done),
        .sw_set    (sw_gie_set),
        .sw_clr    (sw_gie_clr),
        .gie       (gie),
        .hold      (hold)
    );

    irq_entry_fsm #(.N(NUM_SRC), .IW(IW), .PC_W(PC_W), .STRIDE(STRIDE)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .win_idx  (win_idx),
        .pc_in    (pc_in),
        .busy     (busy),
        .push_pc  (push_pc),
        .push_val (push_val),
        .redirect (redirect),
        .vec_addr (vec_addr),
        .ack      (irq_ack)
    );
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
    parameter int unsigned NUM_SRC = 25
) (
    input logic               clk,
    input logic               rst,
    input logic               insn_done,
    input logic               reti_done,
    input logic               gie,
    input logic               push_pc,
    input logic               redirect,
    input logic [NUM_SRC-1:0] irq_ack
);
    // boundaries seen since the last return, saturating at 2
    logic [1:0] gap_cnt;
    always_ff @(posedge clk) begin
        if (rst)                          gap_cnt <= 2'd2;
        else if (reti_done)               gap_cnt <= 2'd0;
        else if (insn_done && gap_cnt != 2'd2) gap_cnt <= gap_cnt + 2'd1;
    end

    AST_ACK_ONEHOT0:    assert property (@(posedge clk) disable iff (rst) $onehot0(irq_ack));                         // R6
    AST_ACK_ON_JUMP:    assert property (@(posedge clk) disable iff (rst) redirect |-> $countones(irq_ack) == 1);      // R6
    AST_JUMP_AFTER_PUSH: assert property (@(posedge clk) disable iff (rst) push_pc |=> redirect && !push_pc);          // R5
    AST_ENTRY_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst) push_pc |-> $past(gie));                    // R4
    AST_ENTRY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst) push_pc |-> $past(insn_done));            // R4
    AST_GIE_OFF_ON_ENTRY: assert property (@(posedge clk) disable iff (rst) push_pc |-> !gie);                         // R7
    AST_RETI_SETS_GIE:  assert property (@(posedge clk) disable iff (rst) (reti_done && !push_pc && !redirect) |=> gie); // R8
    AST_GAP_AFTER_RETI: assert property (@(posedge clk) disable iff (rst) push_pc |-> gap_cnt == 2'd2);                // R9
endmodule

bind irq_sequencer irq_seq_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .insn_done (insn_done),
    .reti_done (reti_done),
    .gie       (gie),
    .push_pc   (push_pc),
    .redirect  (redirect),
    .irq_ack   (irq_ack)
);

// File: tb/tb_irq_sequencer.sv
`timescale 1ns/1ps
module tb_irq_sequencer;
    localparam int N  = 25;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  irq_req;
    logic          insn_done;
    logic [PW-1:0] pc_in;
    logic          reti_done;
    logic          sw_gie_set;
    logic          sw_gie_clr;
    logic          gie;
    logic          push_pc;
    logic [PW-1:0] push_val;
    logic          redirect;
    logic [PW-1:0] vec_addr;
    logic [N-1:0]  irq_ack;

    always #2.5 clk = ~clk;

    irq_sequencer dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .insn_done(insn_done),
        .pc_in(pc_in), .reti_done(reti_done), .sw_gie_set(sw_gie_set),
        .sw_gie_clr(sw_gie_clr), .gie(gie), .push_pc(push_pc),
        .push_val(push_val), .redirect(redirect), .vec_addr(vec_addr),
        .irq_ack(irq_ack)
    );

    typedef struct {
        int            vnum;
        logic [PW-1:0] pc;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    int   pushes = 0;
    bit   prev_push = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: compares observed entries with the scoreboard queue
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_push) chk(redirect, "R5", "redirect after push", redirect, 1);
            if (push_pc) begin
                pushes++;
                if (q.size() == 0) chk(1'b0, "R7", "unexpected entry pc", push_val, 0);
                else chk(push_val == q[0].pc, "R4", "pushed pc", push_val, q[0].pc);
            end
            if (redirect && q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                chk(vec_addr == PW'(e.vnum * 2), "R2", "vector address", vec_addr, e.vnum * 2);
                chk(irq_ack == N'(1) << (e.vnum - 1), "R6", "acknowledge", irq_ack, N'(1) << (e.vnum - 1));
            end
            if (!redirect) chk(irq_ack == '0, "R6", "idle acknowledge", irq_ack, 0);
            prev_push = push_pc;
        end
    end

    // driver: one boundary pulse that is expected to start an entry
    task automatic entry(input int vnum, input logic [PW-1:0] pc);
        exp_t e;
        e.vnum = vnum;
        e.pc   = pc;
        q.push_back(e);
        pc_in     = pc;
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        @(negedge clk);
        @(negedge clk);
        irq_req[vnum-1] = 1'b0;
        chk(gie == 1'b0, "R7", "enable after entry", gie, 0);
    endtask

    task automatic do_reti();
        reti_done = 1'b1;
        @(negedge clk);
        reti_done = 1'b0;
        chk(gie == 1'b1, "R8", "enable after return", gie, 1);
    endtask

    task automatic boundary();
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; irq_req = '0; insn_done = 1'b0; pc_in = '0;
        reti_done = 1'b0; sw_gie_set = 1'b0; sw_gie_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(gie == 1'b0, "R1", "reset enable", gie, 0);
        chk(!push_pc && !redirect, "R1", "reset strobes", {push_pc, redirect}, 0);
        chk(irq_ack == '0, "R1", "reset acknowledge", irq_ack, 0);

        // software control of the enable
        sw_gie_set = 1'b1; @(negedge clk); sw_gie_set = 1'b0;
        chk(gie == 1'b1, "R10", "software set", gie, 1);
        sw_gie_set = 1'b1; sw_gie_clr = 1'b1; @(negedge clk);
        sw_gie_set = 1'b0; sw_gie_clr = 1'b0;
        chk(gie == 1'b0, "R10", "set and clear together", gie, 0);
        irq_req[2] = 1'b1;
        boundary(); repeat (2) @(negedge clk);
        chk(pushes == 0, "R10", "no entry while cleared", pushes, 0);
        irq_req[2] = 1'b0;
        sw_gie_set = 1'b1; @(negedge clk); sw_gie_set = 1'b0;

        // no boundary means no entry
        irq_req[4] = 1'b1;
        repeat (3) @(negedge clk);
        chk(pushes == 0, "R4", "no entry without boundary", pushes, 0);
        entry(5, 16'h1234);

        // enable is off: requests and boundaries must not enter
        irq_req[0]  = 1'b1;
        irq_req[19] = 1'b1;
        insn_done = 1'b1; repeat (4) @(negedge clk); insn_done = 1'b0;
        @(negedge clk);
        chk(pushes == 1, "R7", "no entry while masked", pushes, 1);

        // return, then first boundary must not enter
        do_reti();
        boundary(); repeat (2) @(negedge clk);
        chk(pushes == 1, "R9", "first boundary after return", pushes, 1);
        entry(1, 16'h0456);                  // R3: bit 0 beats bit 19
        chk(pushes == 2, "R3", "entry count", pushes, 2);

        do_reti(); boundary();
        entry(20, 16'hBEEF);

        // highest vector alone, and a lower one appearing alongside
        do_reti(); boundary();
        irq_req[24] = 1'b1;
        entry(25, 16'h7FFE);                 // R2: address 50
        do_reti(); boundary();
        irq_req[23] = 1'b1; irq_req[6] = 1'b1;
        entry(7, 16'h0010);                  // R3
        do_reti(); boundary();
        entry(24, 16'h0020);

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R5", "scoreboard drained", q.size(), 0);
        chk(pushes == 6, "R4", "total entries", pushes, 6);
        summary();
        $finish;
    end
endmodule